// File: doc/BRIEF.md
# Cascadable Serial-In Segment Data Register

This block is the logic front end of a static segment display driver. Segment data arrives one bit at a time on a serial data pin. It is clocked into a 38-stage shift register on falling edges of a serial clock, but only while an active-low select is asserted. A load strobe then copies the register into a 38-bit output latch. The latch is transparent: while the strobe is high, the segment outputs follow the register. When the strobe drops, the outputs keep the last value.

Three serial tap outputs are re-timed on the rising edge of the serial clock. They are taken from stages 30, 32 and 38. A downstream driver that samples on the falling edge therefore sees data that has already settled. This lets several drivers be chained into one longer register, and it lets software read back the shifted pattern. If the load strobe is raised while the select is inactive, a sticky flag records the setup violation.

The serial clock, select, data and load pins are sampled on a fast system clock `clk`. The serial clock edges are found by comparing the pin with its value on the previous `clk` cycle.

Top module: `serial_seg_register`

## Requirements
- R1: A synchronous active-high `rst` clears the shift register, the output latch, the three tap registers and `load_err` to 0. With `load` low after reset, `seg_data` reads all zeros.
- R2: A falling edge of `sclk` is one `clk` cycle with `sclk` = 0 after a cycle with `sclk` = 1. On such an edge with `cs_n` = 0, `din` enters stage 1, and every stage k takes the old value of stage k-1.
- R3: Falling edges of `sclk` while `cs_n` = 1 leave the shift register unchanged.
- R4: While `load` = 1, `seg_data` equals the current shift register contents in the same cycle, with no register delay.
- R5: While `load` = 0, `seg_data` holds the value it had when `load` was last high, whatever shifting happens.
- R6: On a rising edge of `sclk` (one `clk` cycle with `sclk` = 1 after a cycle with `sclk` = 0), the taps capture stages 30, 32 and 38. These go to `tap_out[0]`, `tap_out[1]` and `tap_out[2]` respectively. Between rising edges, including the half period after a falling edge, the taps hold their values.
- R7: After 38 selected falling edges, the first bit shifted in sits at stage 38, which is `seg_data[37]`.
- R8: `load` = 1 while `cs_n` = 1 sets `load_err` from the next cycle, and it stays set until `rst`. The latch still follows the register during that strobe.
- R9: `seg_data[i]` carries stage i+1, for i from 0 to 37.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples all pins |
| rst | input | 1 | Synchronous active-high reset |
| sclk | input | 1 | Serial shift clock; shifts on its falling edge, taps on its rising edge |
| cs_n | input | 1 | Active-low select that enables shifting |
| din | input | 1 | Serial data into stage 1 |
| load | input | 1 | Latch strobe; the latch is transparent while high |
| seg_data | output | 38 | Latched segment data; bit i is stage i+1 |
| tap_out | output | 3 | Re-timed taps of stages 30, 32 and 38 |
| load_err | output | 1 | Sticky flag: load raised while select was inactive |

## Verification
On every cycle, assertions check several relations. Each selected falling edge moves the register one stage with `din` entering stage 1. The register holds steady at all other times. Taps change only on a rising edge, to the stage values before that edge. When `load` falls, the outputs hold the register value from the previous cycle. The error flag is sticky and sets whenever `load` is high without select.

Only the bench scenarios can show whole-pattern behaviour, and they use several bit patterns. These scenarios confirm that the first bit ends up at stage 38 after a full frame. They confirm that shifting with `cs_n` high leaves the latched pattern untouched. They also confirm that the outputs are frozen while new data streams in between strobes.

// File: rtl/ssr_pkg.sv
package ssr_pkg;
  typedef struct packed {
    logic fall;
    logic rise;
  } sclk_ev_t;

  // Select one of three tap stage numbers by index.
  function automatic int tap_stage(input int idx, input int s0, input int s1, input int s2);
    if (idx == 0) return s0;
    else if (idx == 1) return s1;
    else return s2;
  endfunction

  // Stage number (1-based) to vector index.
  function automatic int stage_bit(input int stage);
    return stage - 1;
  endfunction
endpackage

// File: rtl/ssr_edge.sv
module ssr_edge
  import ssr_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     sclk,
  output sclk_ev_t ev
);
  logic sclk_d;

  always_ff @(posedge clk) begin
    if (rst) sclk_d <= 1'b1;
    else     sclk_d <= sclk;
  end

  assign ev.fall = sclk_d & ~sclk;
  assign ev.rise = ~sclk_d & sclk;

  p_edges_excl_r2: assert property (@(posedge clk) disable iff (rst)
    !(ev.fall && ev.rise));
endmodule

// File: rtl/ssr_shift.sv
module ssr_shift #(
  parameter int STAGES = 38
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fall,
  input  logic              cs_n,
  input  logic              din,
  output logic [STAGES-1:0] sreg
);
  logic shift_go;
  assign shift_go = fall & ~cs_n;

  always_ff @(posedge clk) begin
    if (rst)           sreg <= '0;
    else if (shift_go) sreg <= {sreg[STAGES-2:0], din};
  end

  p_shift_move_r2: assert property (@(posedge clk) disable iff (rst)
    shift_go |=> (sreg[0] == $past(din)) && (sreg[STAGES-1:1] == $past(sreg[STAGES-2:0])));
  p_shift_hold_r3: assert property (@(posedge clk) disable iff (rst)
    !shift_go |=> $stable(sreg));
endmodule

// File: rtl/ssr_taps.sv
module ssr_taps
  import ssr_pkg::*;
#(
  parameter int STAGES = 38,
  parameter int TAP0   = 30,
  parameter int TAP1   = 32,
  parameter int TAP2   = 38
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rise,
  input  logic [STAGES-1:0] sreg,
  output logic [2:0]        tap_q
);
  for (genvar k = 0; k < 3; k++) begin : g_tap
    localparam int STG = tap_stage(k, TAP0, TAP1, TAP2);
    localparam int IDX = stage_bit(STG);

    always_ff @(posedge clk) begin
      if (rst)       tap_q[k] <= 1'b0;
      else if (rise) tap_q[k] <= sreg[IDX];
    end

    p_tap_capture_r6: assert property (@(posedge clk) disable iff (rst)
      rise |=> tap_q[k] == $past(sreg[IDX]));
    p_tap_hold_r6: assert property (@(posedge clk) disable iff (rst)
      !rise |=> $stable(tap_q[k]));
  end
endmodule

// File: rtl/ssr_hold.sv
module ssr_hold #(
  parameter int STAGES = 38
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [STAGES-1:0] data_in,
  output logic [STAGES-1:0] data_out
);
  logic [STAGES-1:0] held;

  always_ff @(posedge clk) begin
    if (rst)       held <= '0;
    else if (load) held <= data_in;
  end

  // Transparent while load is high, frozen otherwise.
  assign data_out = load ? data_in : held;

  p_release_r5: assert property (@(posedge clk) disable iff (rst)
    $fell(load) |-> data_out == $past(data_in));
  p_frozen_r5: assert property (@(posedge clk) disable iff (rst)
    !load |=> (load || $stable(data_out)));
endmodule

// File: rtl/serial_seg_register.sv
module serial_seg_register
  import ssr_pkg::*;
#(
  parameter int STAGES = 38,
  parameter int TAP0   = 30,
  parameter int TAP1   = 32,
  parameter int TAP2   = 38
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sclk,
  input  logic              cs_n,
  input  logic              din,
  input  logic              load,
  output logic [STAGES-1:0] seg_data,
  output logic [2:0]        tap_out,
  output logic              load_err
);
  sclk_ev_t          ev;
  logic [STAGES-1:0] sreg;
  logic              bad_load;

  ssr_edge u_edge (.clk(clk), .rst(rst), .sclk(sclk), .ev(ev));

  ssr_shift #(.STAGES(STAGES)) u_shift (
    .clk(clk), .rst(rst), .fall(ev.fall), .cs_n(cs_n), .din(din), .sreg(sreg));

  ssr_taps #(.STAGES(STAGES), .TAP0(TAP0), .TAP1(TAP1), .TAP2(TAP2)) u_taps (
    .clk(clk), .rst(rst), .rise(ev.rise), .sreg(sreg), .tap_q(tap_out));

  ssr_hold #(.STAGES(STAGES)) u_hold (
    .clk(clk), .rst(rst), .load(load), .data_in(sreg), .data_out(seg_data));

  assign bad_load = load & cs_n;

  always_ff @(posedge clk) begin
    if (rst)           load_err <= 1'b0;
    else if (bad_load) load_err <= 1'b1;
  end

  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (sreg == '0) && (tap_out == 3'b000) && !load_err);
  p_err_set_r8: assert property (@(posedge clk) disable iff (rst)
    bad_load |=> load_err);
  p_err_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    load_err |=> load_err);
endmodule

// File: tb/serial_seg_register_bench.sv
module serial_seg_register_bench;
  localparam int CLK_PERIOD = 10;
  localparam int N = 38;

  logic clk = 1'b0;
  logic rst, sclk, cs_n, din, load;
  logic [N-1:0] seg_data;
  logic [2:0]   tap_out;
  logic         load_err;

  int n_chk = 0;
  int n_bad = 0;
  logic [N-1:0] exp_reg;
  logic [N-1:0] exp_seg;
  logic [2:0]   exp_tap;

  serial_seg_register u_serial_seg_register (
    .clk(clk), .rst(rst), .sclk(sclk), .cs_n(cs_n), .din(din), .load(load),
    .seg_data(seg_data), .tap_out(tap_out), .load_err(load_err));

  always #(CLK_PERIOD/2) clk = ~clk;

  initial begin
    #(CLK_PERIOD * 150000);
    n_bad++;
    $display("FAIL watchdog: run did not finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  task automatic chk(input string req, input logic [N-1:0] got, input logic [N-1:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  function automatic logic [2:0] taps_of(input logic [N-1:0] r);
    return {r[37], r[31], r[29]};
  endfunction

  function automatic logic pat_bit(input int p, input int i);
    case (p)
      0: return logic'(i % 2);
      1: return 1'b1;
      2: return logic'(i == 5);
      default: return logic'(((i * 7 + 3) % 5) == 0);
    endcase
  endfunction

  // One full serial clock period: falling half then rising half.
  task automatic shift_bit(input logic b, input logic sel);
    @(negedge clk);
    din = b; cs_n = ~sel; sclk = 1'b0;
    if (sel) exp_reg = {exp_reg[N-2:0], b};
    @(negedge clk);
    chk("R6 taps hold after fall", {35'd0, tap_out}, {35'd0, exp_tap});
    chk("R5 outputs frozen", seg_data, exp_seg);
    sclk = 1'b1;
    @(negedge clk);
    exp_tap = taps_of(exp_reg);
    chk("R6 taps after rise", {35'd0, tap_out}, {35'd0, exp_tap});
  endtask

  task automatic strobe(input logic sel);
    @(negedge clk);
    cs_n = ~sel; load = 1'b1;
    #1;
    exp_seg = exp_reg;
    chk("R4 R9 transparent", seg_data, exp_seg);
    @(negedge clk);
    chk("R4 still following", seg_data, exp_seg);
    load = 1'b0;
    @(negedge clk);
    chk("R5 held after strobe", seg_data, exp_seg);
  endtask

  initial begin
    rst = 1'b1; sclk = 1'b1; cs_n = 1'b1; din = 1'b0; load = 1'b0;
    exp_reg = '0; exp_seg = '0; exp_tap = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 reset seg", seg_data, '0);
    chk("R1 reset taps", {35'd0, tap_out}, '0);
    chk("R1 reset err", {37'd0, load_err}, '0);

    for (int p = 0; p < 4; p++) begin
      for (int i = 0; i < N; i++) shift_bit(pat_bit(p, i), 1'b1);
      strobe(1'b1);
      chk("R7 first bit at stage 38", {37'd0, seg_data[37]}, {37'd0, pat_bit(p, 0)});
      chk("R2 last bit at stage 1", {37'd0, seg_data[0]}, {37'd0, pat_bit(p, N-1)});
      for (int i = 0; i < 3; i++) shift_bit(~pat_bit(p, i), 1'b1);
      chk("R5 frozen after extra shifts", seg_data, exp_seg);
    end

    // Walking one across every stage.
    for (int s = 0; s < N; s++) begin
      for (int i = 0; i < N; i++) shift_bit(logic'(i == N - 1 - s), 1'b1);
      strobe(1'b1);
      chk("R9 walking one", seg_data, {{(N-1){1'b0}}, 1'b1} << s);
    end

    // Deselected shifting changes nothing.
    for (int i = 0; i < 10; i++) shift_bit(logic'(i % 3 == 0), 1'b0);
    strobe(1'b1);
    chk("R3 deselected shifts ignored", seg_data, exp_reg);
    chk("R8 no error yet", {37'd0, load_err}, '0);

    // Load while deselected.
    for (int i = 0; i < 4; i++) shift_bit(1'b1, 1'b1);
    strobe(1'b0);
    chk("R8 error set", {37'd0, load_err}, {37'd0, 1'b1});
    chk("R8 latch followed", seg_data, exp_reg);
    shift_bit(1'b0, 1'b1);
    strobe(1'b1);
    chk("R8 error sticky", {37'd0, load_err}, {37'd0, 1'b1});

    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 reset seg again", seg_data, '0);
    chk("R1 reset taps again", {35'd0, tap_out}, '0);
    chk("R1 error cleared", {37'd0, load_err}, '0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule